// File: doc/BRIEF.md
# Reset-Configured FIFO Channel with Status Flags

This block is a single-clock first-in first-out buffer. It has one write side and one read side, and it reports its fill state through four level flags and a one-cycle echo strobe. Two settings are sampled only while the master reset input is high and then stay fixed until the next master reset. The first is the read-out style: standard, or first-word-fall-through. The second is a 2-bit select that picks one shared offset for the almost-empty and almost-full flags.

In standard mode, a word is read by raising `rd_req` while the buffer holds data, and the word shows on `rd_data` after the next clock edge. In fall-through mode, the oldest word is presented on `rd_data` without any request. `rd_req` then acts as the ready half of a valid/ready pair, where `out_flag` is the valid, and a word is consumed on any edge where both are high. The write side follows the same stream rule with back-pressure. A word on `wr_data` is taken on an edge where `wr_valid` is high and the buffer is not full. While the buffer is full, the producer must hold the word and keep `wr_valid` high, because a write offered then is dropped. A read offered while nothing can be read is dropped in the same way.

`echo_rd` pulses for one cycle whenever a read has just put a new word on `rd_data`. A consumer can use it as a data strobe.

Top module: `cfg_fifo_chan`

## Requirements
- R1: `cfg_fwft` and `cfg_ofs_sel` are captured on every clock edge with `mrst` high and are ignored on every edge with `mrst` low. Changing them during operation changes no output.
- R2: The captured select sets one offset that both almost flags use: 2'b00 gives 7, 2'b01 gives 63, 2'b10 gives 127 and 2'b11 gives 1023.
- R3: After master reset the buffer holds no words and `echo_rd` is 0. In standard mode (`cfg_fwft`=0 at reset) `out_flag`=1 and `in_flag`=0. In fall-through mode (`cfg_fwft`=1) `out_flag`=0 and `in_flag`=1.
- R4: In standard mode, `out_flag` is 1 exactly when no words are stored and `in_flag` is 1 exactly when DEPTH words are stored. Both follow an accepted write or read one clock edge later.
- R5: In standard mode, an edge with `rd_req`=1 and `out_flag`=0 loads the oldest stored word onto `rd_data`. Words come out in the order they were written.
- R6: In fall-through mode, the oldest word appears on `rd_data` without a request, and `out_flag` becomes 1 two edges after a write into an empty buffer. `out_flag` returns to 0 only after the last word has been consumed. `in_flag` is 1 whenever fewer than DEPTH words are held.
- R7: The occupancy counts the stored words, plus the word on the output in fall-through mode. `almost_empty` is 1 when the occupancy is at or below the offset. `almost_full` is 1 when DEPTH minus the occupancy is at or below the offset.
- R8: `echo_rd` is 1 for one cycle after each edge where a read was accepted and a new word was put on `rd_data`. In standard mode that is every accepted read. In fall-through mode it is a consume that brought a following word forward.
- R9: A write offered while DEPTH words are held and a read offered while nothing can be read are ignored. Contents, order and flags are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both sides |
| mrst | input | 1 | Synchronous master reset, active high; configuration is captured while it is high |
| cfg_fwft | input | 1 | Read-out style captured at reset: 1 = fall-through, 0 = standard |
| cfg_ofs_sel | input | 2 | Almost-flag offset select captured at reset |
| wr_valid | input | 1 | Write request / data valid |
| wr_data | input | DATA_W | Write word |
| rd_req | input | 1 | Read request (standard) or consumer ready (fall-through) |
| rd_data | output | DATA_W | Read word |
| out_flag | output | 1 | Empty (standard) or output-ready (fall-through) |
| in_flag | output | 1 | Full (standard) or input-ready (fall-through) |
| almost_empty | output | 1 | Occupancy at or below the offset |
| almost_full | output | 1 | Free space at or below the offset |
| echo_rd | output | 1 | One-cycle strobe marking a new word placed by a read |

## Verification
All flags and the almost flags depend on registered counts. A write or read accepted on one rising edge is visible right after that edge, and the same holds for `rd_data` and `echo_rd` after a standard read. In fall-through mode, a write into an empty buffer reaches `rd_data` and `out_flag` one edge later still, after the second edge. The bench drives inputs at the falling edge and advances its reference queue at the rising edge. It then compares every output at the following falling edge, so each result is checked in the cycle it falls due. Every offset select is run in both modes, filled past full and drained past empty, and the configuration inputs are then changed outside reset.

// File: rtl/cfg_fifo_pkg.sv
package cfg_fifo_pkg;

  typedef enum logic {
    RD_STD  = 1'b0,
    RD_FWFT = 1'b1
  } rd_mode_e;

  localparam int OFS_W = 10;

  // Default offset for the almost flags, picked at master reset
  function automatic logic [OFS_W-1:0] ofs_decode(input logic [1:0] sel);
    logic [OFS_W-1:0] v;
    case (sel)
      2'b00:   v = OFS_W'(7);
      2'b01:   v = OFS_W'(63);
      2'b10:   v = OFS_W'(127);
      default: v = OFS_W'(1023);
    endcase
    return v;
  endfunction

endpackage

// File: rtl/cfg_fifo_cfg.sv
module cfg_fifo_cfg
  import cfg_fifo_pkg::*;
(
  input  logic             clk,
  input  logic             mrst,
  input  logic             cfg_fwft,
  input  logic [1:0]       cfg_ofs_sel,
  output rd_mode_e         mode_q,
  output logic [OFS_W-1:0] ofs_q
);

  // Straps are only sampled while master reset is held
  always_ff @(posedge clk) begin
    if (mrst) begin
      mode_q <= rd_mode_e'(cfg_fwft);
      ofs_q  <= ofs_decode(cfg_ofs_sel);
    end
  end

endmodule

// File: rtl/cfg_fifo_store.sv
module cfg_fifo_store #(
  parameter  int DATA_W = 10,
  parameter  int DEPTH  = 2048,
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              mrst,
  input  logic              push,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              pop,
  output logic [DATA_W-1:0] rd_data,
  output logic [CNT_W-1:0]  mem_cnt
);

  localparam bit POW2 = ((DEPTH & (DEPTH - 1)) == 0);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wptr, rptr, wptr_nx, rptr_nx;

  generate
    if (POW2) begin : g_wrap_nat
      assign wptr_nx = wptr + 1'b1;
      assign rptr_nx = rptr + 1'b1;
    end else begin : g_wrap_cmp
      assign wptr_nx = (wptr == PTR_W'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      assign rptr_nx = (rptr == PTR_W'(DEPTH - 1)) ? '0 : rptr + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (mrst) begin
      wptr    <= '0;
      rptr    <= '0;
      mem_cnt <= '0;
      rd_data <= '0;
    end else begin
      if (push) wptr <= wptr_nx;
      if (pop) begin
        rptr    <= rptr_nx;
        rd_data <= mem[rptr];
      end
      case ({push, pop})
        2'b10:   mem_cnt <= mem_cnt + 1'b1;
        2'b01:   mem_cnt <= mem_cnt - 1'b1;
        default: mem_cnt <= mem_cnt;
      endcase
    end
  end

endmodule

// File: rtl/cfg_fifo_flags.sv
module cfg_fifo_flags
  import cfg_fifo_pkg::*;
#(
  parameter  int DEPTH = 2048,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  rd_mode_e         mode,
  input  logic [OFS_W-1:0] ofs,
  input  logic [CNT_W-1:0] mem_cnt,
  input  logic             out_valid,
  output logic [CNT_W-1:0] occ,
  output logic             out_flag,
  output logic             in_flag,
  output logic             almost_empty,
  output logic             almost_full
);

  logic [CNT_W-1:0] free_sp;
  logic [CNT_W-1:0] ofs_ext;
  logic             full;

  always_comb begin
    occ      = mem_cnt + ((mode == RD_FWFT) ? CNT_W'(out_valid) : '0);
    free_sp  = CNT_W'(DEPTH) - occ;
    ofs_ext  = CNT_W'(ofs);
    full     = (occ == CNT_W'(DEPTH));
    almost_empty = (occ <= ofs_ext);
    almost_full  = (free_sp <= ofs_ext);
    if (mode == RD_FWFT) begin
      out_flag = out_valid;
      in_flag  = !full;
    end else begin
      out_flag = (mem_cnt == '0);
      in_flag  = full;
    end
  end

endmodule

// File: rtl/cfg_fifo_chan.sv
module cfg_fifo_chan
  import cfg_fifo_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int DEPTH  = 2048
) (
  input  logic              clk,
  input  logic              mrst,
  input  logic              cfg_fwft,
  input  logic [1:0]        cfg_ofs_sel,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_req,
  output logic [DATA_W-1:0] rd_data,
  output logic              out_flag,
  output logic              in_flag,
  output logic              almost_empty,
  output logic              almost_full,
  output logic              echo_rd
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  rd_mode_e         mode_q;
  logic [OFS_W-1:0] ofs_q;
  logic [CNT_W-1:0] mem_cnt, occ;
  logic             out_valid, push, pop, take, echo_nx;

  cfg_fifo_cfg u_cfg (
    .clk         (clk),
    .mrst        (mrst),
    .cfg_fwft    (cfg_fwft),
    .cfg_ofs_sel (cfg_ofs_sel),
    .mode_q      (mode_q),
    .ofs_q       (ofs_q)
  );

  cfg_fifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .mrst    (mrst),
    .push    (push),
    .wr_data (wr_data),
    .pop     (pop),
    .rd_data (rd_data),
    .mem_cnt (mem_cnt)
  );

  cfg_fifo_flags #(.DEPTH(DEPTH)) u_flags (
    .mode         (mode_q),
    .ofs          (ofs_q),
    .mem_cnt      (mem_cnt),
    .out_valid    (out_valid),
    .occ          (occ),
    .out_flag     (out_flag),
    .in_flag      (in_flag),
    .almost_empty (almost_empty),
    .almost_full  (almost_full)
  );

  // Accept/consume decisions; pop moves a word from memory to rd_data
  always_comb begin
    push = wr_valid && (occ < CNT_W'(DEPTH));
    if (mode_q == RD_FWFT) begin
      take = rd_req && out_valid;
      pop  = (mem_cnt != '0) && (!out_valid || take);
    end else begin
      take = rd_req && (mem_cnt != '0);
      pop  = take;
    end
    echo_nx = take && pop;
  end

  always_ff @(posedge clk) begin
    if (mrst) begin
      out_valid <= 1'b0;
      echo_rd   <= 1'b0;
    end else begin
      echo_rd <= echo_nx;
      if (mode_q != RD_FWFT) out_valid <= 1'b0;
      else if (pop)          out_valid <= 1'b1;
      else if (take)         out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/cfg_fifo_chk.sv
module cfg_fifo_chk
  import cfg_fifo_pkg::*;
#(
  parameter  int DEPTH = 2048,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             mrst,
  input logic             wr_valid,
  input logic             rd_req,
  input rd_mode_e         mode_q,
  input logic [OFS_W-1:0] ofs_q,
  input logic [CNT_W-1:0] mem_cnt,
  input logic             out_flag,
  input logic             in_flag,
  input logic             almost_empty,
  input logic             almost_full,
  input logic             echo_rd
);

  p_cfg_hold_r1: assert property (@(posedge clk) disable iff (mrst)
    !$past(mrst) |-> ($stable(mode_q) && $stable(ofs_q)));

  p_ofs_legal_r2: assert property (@(posedge clk) disable iff (mrst)
    (ofs_q == 10'd7 || ofs_q == 10'd63 || ofs_q == 10'd127 || ofs_q == 10'd1023));

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (mrst)
    (mode_q == RD_STD && in_flag && !rd_req) |=> in_flag);

  p_no_underflow_r9: assert property (@(posedge clk) disable iff (mrst)
    (mode_q == RD_STD && out_flag && !wr_valid) |=> out_flag);

  p_echo_needs_read_r8: assert property (@(posedge clk) disable iff (mrst)
    echo_rd |-> $past(rd_req));

  p_echo_has_word_r8: assert property (@(posedge clk) disable iff (mrst)
    (mode_q == RD_FWFT && echo_rd) |-> out_flag);

  p_empty_is_low_r7: assert property (@(posedge clk) disable iff (mrst)
    (mode_q == RD_STD && out_flag) |-> almost_empty);

  p_full_is_high_r7: assert property (@(posedge clk) disable iff (mrst)
    (mode_q == RD_STD && in_flag) |-> almost_full);

  p_fall_through_r6: assert property (@(posedge clk) disable iff (mrst)
    (mode_q == RD_FWFT && !out_flag && mem_cnt != '0) |=> out_flag);

endmodule

bind cfg_fifo_chan cfg_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk          (clk),
  .mrst         (mrst),
  .wr_valid     (wr_valid),
  .rd_req       (rd_req),
  .mode_q       (mode_q),
  .ofs_q        (ofs_q),
  .mem_cnt      (mem_cnt),
  .out_flag     (out_flag),
  .in_flag      (in_flag),
  .almost_empty (almost_empty),
  .almost_full  (almost_full),
  .echo_rd      (echo_rd)
);

// File: tb/cfg_fifo_chan_tb.sv
`timescale 1ns/1ps
module cfg_fifo_chan_tb_top;

  localparam int DW    = 10;
  localparam int DEPTH = 2048;
  localparam int WDOG  = 190000;

  logic          clk = 1'b0;
  logic          mrst = 1'b1;
  logic          cfg_fwft = 1'b0;
  logic [1:0]    cfg_ofs_sel = 2'b00;
  logic          wr_valid = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          rd_req = 1'b0;
  logic [DW-1:0] rd_data;
  logic          out_flag, in_flag, almost_empty, almost_full, echo_rd;

  always #2 clk = ~clk;

  cfg_fifo_chan #(.DATA_W(DW), .DEPTH(DEPTH)) dut_i (
    .clk          (clk),
    .mrst         (mrst),
    .cfg_fwft     (cfg_fwft),
    .cfg_ofs_sel  (cfg_ofs_sel),
    .wr_valid     (wr_valid),
    .wr_data      (wr_data),
    .rd_req       (rd_req),
    .rd_data      (rd_data),
    .out_flag     (out_flag),
    .in_flag      (in_flag),
    .almost_empty (almost_empty),
    .almost_full  (almost_full),
    .echo_rd      (echo_rd)
  );

  int n_checks = 0;
  int n_errors = 0;
  int cycles   = 0;

  // Reference state
  logic [DW-1:0] q[$];
  bit            m_fwft;
  int            m_ofs;
  bit            m_ov;
  bit            m_echo;
  logic [DW-1:0] m_data;
  string         phase;

  function automatic int exp_ofs(input logic [1:0] sel);
    if (sel == 2'b00) return 7;
    if (sel == 2'b01) return 63;
    if (sel == 2'b10) return 127;
    return 1023;
  endfunction

  function automatic int m_occ();
    return q.size() + ((m_fwft && m_ov) ? 1 : 0);
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s [%s] %s: actual %0d expected %0d", req, phase, what, act, exp);
    end
  endtask

  task automatic compare_all();
    int  occ;
    occ = m_occ();
    if (m_fwft) begin
      chk("R6", "output-ready", int'(out_flag), int'(m_ov));
      chk("R6", "input-ready", int'(in_flag), int'(occ < DEPTH));
      if (m_ov) chk("R6", "head word", int'(rd_data), int'(m_data));
    end else begin
      chk("R4", "empty", int'(out_flag), int'(q.size() == 0));
      chk("R4", "full", int'(in_flag), int'(occ == DEPTH));
      if (m_echo) chk("R5", "read word", int'(rd_data), int'(m_data));
    end
    chk("R7", "almost_empty", int'(almost_empty), int'(occ <= m_ofs));
    chk("R7", "almost_full", int'(almost_full), int'((DEPTH - occ) <= m_ofs));
    chk("R8", "echo", int'(echo_rd), int'(m_echo));
  endtask

  task automatic model_edge(input bit wv, input logic [DW-1:0] wd, input bit rr);
    int  sz;
    bit  wf, take, pop;
    sz = q.size();
    wf = wv && (m_occ() < DEPTH);
    if (m_fwft) begin
      take = rr && m_ov;
      pop  = (sz > 0) && (!m_ov || take);
    end else begin
      take = rr && (sz > 0);
      pop  = take;
    end
    m_echo = take && pop;
    if (pop) begin
      m_data = q.pop_front();
      if (m_fwft) m_ov = 1'b1;
    end else if (take && m_fwft) begin
      m_ov = 1'b0;
    end
    if (wf) q.push_back(wd);
  endtask

  task automatic cyc(input bit wv, input bit rr);
    logic [DW-1:0] wd;
    wd       = DW'($urandom);
    wr_valid = wv;
    wr_data  = wd;
    rd_req   = rr;
    @(posedge clk);
    model_edge(wv, wd, rr);
    @(negedge clk);
    compare_all();
  endtask

  task automatic do_reset(input bit fw, input logic [1:0] sel);
    phase       = "reset";
    cfg_fwft    = fw;
    cfg_ofs_sel = sel;
    wr_valid    = 1'b0;
    rd_req      = 1'b0;
    mrst        = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    mrst   = 1'b0;
    q.delete();
    m_fwft = fw;
    m_ofs  = exp_ofs(sel);
    m_ov   = 1'b0;
    m_echo = 1'b0;
    // R3: reset state of every flag
    chk("R3", "out_flag after reset", int'(out_flag), fw ? 0 : 1);
    chk("R3", "in_flag after reset", int'(in_flag), fw ? 1 : 0);
    chk("R3", "echo after reset", int'(echo_rd), 0);
    chk("R2", "almost_empty after reset", int'(almost_empty), 1);
    chk("R2", "almost_full after reset", int'(almost_full), int'(DEPTH <= m_ofs));
  endtask

  task automatic run_cfg(input bit fw, input logic [1:0] sel);
    do_reset(fw, sel);
    // R2/R7: walk every occupancy up through the offset and past full (R9)
    phase = "R9_fill";
    for (int i = 0; i < DEPTH + 4; i++) cyc(1'b1, 1'b0);
    phase = "R9_drain";
    for (int i = 0; i < DEPTH + 4; i++) cyc(1'b0, 1'b1);
    phase = "random";
    for (int i = 0; i < 600; i++) cyc(($urandom % 100) < 60, ($urandom % 100) < 45);
    // R1: straps move outside reset; latched behaviour must hold
    phase = "R1_straps";
    cfg_fwft    = ~fw;
    cfg_ofs_sel = ~sel;
    for (int i = 0; i < 300; i++) cyc(($urandom % 100) < 45, ($urandom % 100) < 55);
  endtask

  task automatic fwft_corner();
    do_reset(1'b1, 2'b00);
    phase = "R6_corner";
    cyc(1'b1, 1'b0);
    chk("R6", "not ready one edge after first write", int'(out_flag), 0);
    cyc(1'b0, 1'b0);
    chk("R6", "ready two edges after first write", int'(out_flag), 1);
    cyc(1'b0, 1'b1);
    chk("R8", "no echo when last word consumed", int'(echo_rd), 0);
    chk("R6", "ready drops after last word", int'(out_flag), 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int m = 0; m < 2; m++)
      for (int s = 0; s < 4; s++)
        run_cfg(m[0], s[1:0]);
    fwft_corner();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WDOG) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual %0d cycles expected at most %0d", cycles, WDOG);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

endmodule